// File: doc/BRIEF.md
# Protected-write system clock prescaler

This block divides the system clock by a power of two chosen by a 4-bit select field held in an 8-bit control register. The register sits on a simple synchronous bus: a write strobe with write data, and read data that always shows the current contents. The output is a single-cycle clock-enable pulse at the divided rate. Logic that is meant to run at the reduced rate qualifies its flops with this pulse. A second output reports the ratio that is currently in force.

The select field is guarded so that a stray write cannot change the frequency. Software first writes the register with only the top bit set. This opens a short window. A write with the top bit clear must arrive within the next four cycles, and it loads the new select value. The window then closes at once. If no such write arrives, the window closes by itself after four cycles. A new ratio is taken over only at the end of the divide period that is running, so the pulse train never shows a shortened or lengthened interval.

Top module: `sysclk_prescaler`

## Requirements
- R1: A read returns the unlock flag in bit 7, zero in bits 6..4 and the stored select value in bits 3..0. Bits 6..4 ignore writes.
- R2: After reset the unlock flag is 0, the stored select value and the active ratio equal the DEF_SEL parameter, and the divider starts a fresh period.
- R3: Only a write of exactly 8'h80 sets the unlock flag. A write that has bit 7 set together with any other bit set leaves the flag at 0.
- R4: While the flag is set, a write with bit 7 clear loads bits 3..0 into the select field and clears the flag on the same edge. Such a write is accepted on any of the four clock edges that follow the unlocking write.
- R5: If no select write arrives, the flag clears on the fourth edge after the unlocking write. A select write after that edge is ignored.
- R6: Writing 8'h80 again while the window is open neither restarts the four-cycle window nor clears the flag.
- R7: While the flag is 0, any write leaves the select field unchanged. This includes writes with bit 7 set and other bits nonzero.
- R8: A select value n in 0..8 gives one clock-enable pulse every 2^n cycles. Values 9..15 behave as divide-by-1, so the enable is high on every cycle.
- R9: A newly stored select value becomes active, and appears on divSel, only at the edge that ends the current divide period. Until then, pulses keep the old spacing.
- R10: Under a ratio above 1, the clock enable is a single-cycle pulse, and the first pulse after reset or after a ratio change falls exactly one full new period after the previous pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data: unlock flag, zeros, stored select |
| clkEn | output | 1 | Divided clock-enable pulse |
| divSel | output | 4 | Select value currently in force |

## Verification
A write presented in one cycle changes the unlock flag and the stored select value at the next rising edge, so regRdata shows the effect one cycle after the write. The unlock window spans the four edges after the unlocking write. clkEn and divSel change only at the edge that ends a divide period, which comes 2^n cycles after the previous one. The bench keeps a behavioural model of the flag, its age, the stored and active ratios and the position within the period. It drives inputs and compares all outputs with the model at every falling edge, so each result is checked in exactly the cycle it is due. Stimulus aims at the window edges: acceptance on the fourth edge, rejection on the fifth, rewrites at the start and at the end of the window, and ratio changes in the middle of a period.

// File: rtl/presc_pkg.sv
package presc_pkg;

  typedef enum logic {
    WIN_LOCKED = 1'b0,
    WIN_OPEN   = 1'b1
  } winState_t;

  typedef struct packed {
    logic openWin;
    logic closeWin;
    logic loadSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int WINDOW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic             unlocked,
  output ctrlStrobes_t     strb
);

  localparam int AGE_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(WINDOW - 1);
  localparam logic [REG_W-1:0] UNLOCK_PATTERN = {1'b1, {(REG_W-1){1'b0}}};

  winState_t        state;
  logic [AGE_W-1:0] age;
  logic             patternHit;
  logic             selWrite;

  assign patternHit = regWe && (regWdata == UNLOCK_PATTERN);
  assign selWrite   = regWe && !regWdata[REG_W-1];

  always_comb begin
    strb.openWin  = (state == WIN_LOCKED) && patternHit;
    strb.loadSel  = (state == WIN_OPEN) && selWrite;
    strb.closeWin = (state == WIN_OPEN) && (selWrite || (age == AGE_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= WIN_LOCKED;
      age   <= '0;
    end else if (strb.openWin) begin
      state <= WIN_OPEN;
      age   <= '0;
    end else if (strb.closeWin) begin
      state <= WIN_LOCKED;
      age   <= '0;
    end else if (state == WIN_OPEN) begin
      age <= age + 1'b1;
    end
  end

  assign unlocked = (state == WIN_OPEN);

  AST_UNLOCK_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(regWe && (regWdata == UNLOCK_PATTERN))); // R3

  AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && (age == AGE_LAST)) |=> !unlocked); // R5

  AST_REWRITE_NO_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && patternHit && (age != AGE_LAST)) |=> (unlocked && (age == $past(age) + 1'b1))); // R6

  AST_LOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !strb.loadSel); // R7

endmodule

// File: rtl/presc_dp.sv
module presc_dp
  import presc_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 8,
  parameter int DEF_SEL   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [SEL_W-1:0] wrSel,
  output logic [SEL_W-1:0] selReg,
  output logic [SEL_W-1:0] actSel,
  output logic             clkEn
);

  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastCnt;
  logic [SEL_W-1:0] shiftAmt;

  // reserved select codes fall back to divide-by-1
  always_comb begin
    if (int'(actSel) <= MAX_SHIFT) shiftAmt = actSel;
    else                           shiftAmt = '0;
  end

  // terminal count = 2^shift - 1, built as a mask of the low bits
  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_mask
      assign lastCnt[gi] = (int'(shiftAmt) > gi);
    end
  endgenerate

  assign clkEn = (divCnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= SEL_W'(DEF_SEL);
    end else if (strb.loadSel) begin
      selReg <= wrSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      actSel <= SEL_W'(DEF_SEL);
    end else if (clkEn) begin
      divCnt <= '0;
      actSel <= selReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(actSel)); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && (selReg == actSel) && (lastCnt != '0)) |=> !clkEn); // R10

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSel |=> $stable(selReg)); // R7

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import presc_pkg::*;
#(
  parameter int WINDOW    = 4,
  parameter int MAX_SHIFT = 8,
  parameter int DEF_SEL   = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       clkEn,
  output logic [3:0] divSel
);

  localparam int REG_W = 8;
  localparam int SEL_W = 4;
  localparam int RSV_W = REG_W - 1 - SEL_W;

  ctrlStrobes_t     strb;
  logic             unlocked;
  logic [SEL_W-1:0] selReg;

  presc_ctrl #(
    .REG_W (REG_W),
    .WINDOW(WINDOW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regWdata(regWdata),
    .unlocked(unlocked),
    .strb    (strb)
  );

  presc_dp #(
    .SEL_W    (SEL_W),
    .MAX_SHIFT(MAX_SHIFT),
    .DEF_SEL  (DEF_SEL)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrSel (regWdata[SEL_W-1:0]),
    .selReg(selReg),
    .actSel(divSel),
    .clkEn (clkEn)
  );

  assign regRdata = {unlocked, {RSV_W{1'b0}}, selReg};

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[REG_W-2:SEL_W] == '0); // R1

  AST_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSel |=> (!regRdata[REG_W-1] && (selReg == $past(regWdata[SEL_W-1:0])))); // R4

endmodule

// File: tb/sysclk_prescaler_tb.sv
module sysclk_prescaler_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       clkEn;
  logic [3:0] divSel;

  int checks = 0;
  int fails = 0;
  string curReq = "R2";

  // behavioural reference state
  int unlockM, ageM, selM, actM, cntM;

  sysclk_prescaler u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .clkEn   (clkEn),
    .divSel  (divSel)
  );

  always #4 clk = ~clk;

  function automatic int periodOf(input int s);
    if (s <= 8) return 1 << s;
    return 1;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    chk("regRdata", int'(regRdata), (unlockM << 7) | selM);
    chk("clkEn", int'(clkEn), (cntM == periodOf(actM) - 1) ? 1 : 0);
    chk("divSel", int'(divSel), actM);
  endtask

  task automatic modelAdvance(input logic we, input logic [7:0] d);
    if (cntM == periodOf(actM) - 1) begin
      cntM = 0;
      actM = selM;
    end else begin
      cntM++;
    end
    if (unlockM == 1) begin
      if (we && !d[7]) begin
        selM = int'(d[3:0]);
        unlockM = 0;
      end else if (ageM == 3) begin
        unlockM = 0;
      end else begin
        ageM++;
      end
    end else if (we && d == 8'h80) begin
      unlockM = 1;
      ageM = 0;
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d);
    @(negedge clk);
    checkOutputs();
    regWe = we;
    regWdata = d;
    modelAdvance(we, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic setRatio(input logic [3:0] s);
    step(1'b1, 8'h80);
    step(1'b1, {4'h0, s});
    step(1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    unlockM = 0; ageM = 0; selM = 0; actM = 0; cntM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R2";
    checkOutputs();
    modelAdvance(1'b0, 8'h00);
    idle(5);

    curReq = "R1";        // reserved bits ignore writes, read layout
    step(1'b1, 8'h80);
    step(1'b1, 8'h72);    // bits 6..4 set, select 2
    idle(4);
    chk("rsv bits", int'(regRdata[6:4]), 0);

    curReq = "R3";        // near-miss unlock patterns
    step(1'b1, 8'h81);
    step(1'b1, 8'hC0);
    step(1'b1, 8'h88);
    step(1'b0, 8'h00);
    chk("flag after near-miss", int'(regRdata[7]), 0);

    curReq = "R7";        // locked writes ignored
    step(1'b1, 8'h07);
    step(1'b1, 8'h8F);
    step(1'b1, 8'h05);
    idle(3);

    curReq = "R4";        // accept on fourth edge after unlock
    step(1'b1, 8'h80);
    idle(3);
    step(1'b1, 8'h03);
    idle(20);

    curReq = "R5";        // fifth edge rejected
    step(1'b1, 8'h80);
    idle(4);
    step(1'b1, 8'h01);
    idle(2);
    chk("sel after expiry", int'(regRdata[3:0]), 3);

    curReq = "R6";        // rewrites inside window
    step(1'b1, 8'h80);
    step(1'b1, 8'h80);
    step(1'b1, 8'h80);
    step(1'b0, 8'h00);
    step(1'b1, 8'h80);    // last window cycle: must not extend
    step(1'b1, 8'h06);    // arrives after expiry: ignored
    idle(2);
    chk("sel after rewrite", int'(regRdata[3:0]), 3);
    step(1'b1, 8'h80);
    step(1'b1, 8'h80);
    step(1'b1, 8'h04);    // accepted, flag still set
    idle(40);

    curReq = "R9";        // mid-period ratio changes
    setRatio(4'h2);
    idle(17);
    setRatio(4'h5);
    idle(70);
    setRatio(4'h0);
    idle(10);

    curReq = "R8";
    for (int s = 0; s < 16; s++) begin
      setRatio(4'(s));
      idle((s <= 8) ? (2 * (1 << s) + 4) : 6);
    end

    curReq = "R10";
    setRatio(4'h1);
    idle(12);
    setRatio(4'h3);
    idle(30);

    summary();
    $finish;
  end

endmodule